// File: doc/BRIEF.md
# Pulse Accumulator

This block is a 16-bit pulse accumulator with its own control, flag and count registers. In event mode it counts one chosen edge (rising or falling) of an external pin. In gated mode it measures how long the pin sits at a chosen level. In that mode it adds one for every 64 clock cycles that the level holds, which gives a time integral of the gate.

The block sets two sticky flags. One marks an input event and one marks a wrap of the count. Each flag has an interrupt enable, and software clears a flag by writing a one to it. The block also drives a one-cycle timer tick, which a neighbouring timer uses as its count clock. Through a select field, that tick comes from the timer's own prescaler, from the accumulator's count pulses, or from those pulses divided by 256 or by 65536.

The divided taps are taken from carries out of the count register itself. Software writes the registers through a single write port, and their contents are visible on dedicated outputs.

Top module: `pulse_acc`

## Requirements
- R1: After reset the control value, the flags and the count are all zero, and the bench sees ctrl_o = 0x00, flags_o = 0 and count_o = 0x0000.
- R2: The write port uses wr_sel_i to pick a register: 0 is the control register, 1 is the flag register (write-one-to-clear) and 2 is the count. The control byte is laid out as follows: bit 6 is the enable; bits 5:4 are the mode (00 falling edges, 01 rising edges, 10 gated while the pin is high, 11 gated while the pin is low); bits 3:2 are the tick select; bits 1:0 are the interrupt enables (bit 0 for the input flag, bit 1 for the overflow flag). Bit 7 always reads 0.
- R3: In event mode the pin passes through two synchronizing flops. Each selected edge then adds exactly one to the count, three clock edges after the pin changes, and the opposite edge adds nothing.
- R4: In gated mode the count rises by one for every 64 clock cycles that the synchronized pin holds the active level. At the inactive level the count does not advance.
- R5: With the enable at 0, the count holds and neither flag sets, whatever the pin does.
- R6: The overflow flag (flags_o bit 1) sets when a count step takes the count from 0xFFFF to 0x0000.
- R7: The input flag (flags_o bit 0) sets on each counted edge in event mode. In gated mode it sets on the edge that ends the active level: a falling edge in mode 10 and a rising edge in mode 11.
- R8: Writing a one to a flag bit clears that flag, and writing a zero leaves it alone. A flag that sets in the same cycle as its clear stays set.
- R9: irq_o is high exactly when some flag is set and its interrupt enable is set.
- R10: A write to the count loads wr_data_i. When it falls in the same cycle as a count step, the written value wins.
- R11: tmr_tick_o follows the tick select. Select 00 passes presc_tick_i through. Select 01 pulses on every count step. Select 10 pulses on a step out of a count whose low byte is 0xFF. Select 11 pulses on a step out of 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous accumulator pin |
| presc_tick_i | input | 1 | Tick from the timer's own prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 control, 1 flags, 2 count) |
| wr_data_i | input | 16 | Write data |
| ctrl_o | output | 8 | Control register contents |
| flags_o | output | 2 | Overflow flag (bit 1) and input flag (bit 0) |
| count_o | output | 16 | Accumulator count |
| irq_o | output | 1 | Interrupt request |
| tmr_tick_o | output | 1 | Selected timer tick |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a flag that sets while software clears it by writing a one. The second pair is a count step while software loads the count. To provoke each collision, the bench raises the pin and places the register write exactly on the third edge after the pin changes, which is the edge where the synchronized step lands. It then judges the pair at the ports: the flag must still read set, and the count must hold the written value and not the incremented one.

// File: rtl/pulse_acc.sv
module pulse_acc #(
  parameter int CW       = 16,
  parameter int GATE_DIV = 64,
  parameter int TAP_BITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  logic          presc_tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [7:0]    ctrl_o,
  output logic [1:0]    flags_o,
  output logic [CW-1:0] count_o,
  output logic          irq_o,
  output logic          tmr_tick_o
);
  localparam int DW = $clog2(GATE_DIV);

  logic          en_q;
  logic [1:0]    mode_q, csel_q, ie_q, flg_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    sync_q;
  logic [DW-1:0] div_q;

  logic rise, fall, edge_sel, lvl_on, div_tick, cnt_tick, in_evt, wrap, tap;
  logic wr_ctrl, wr_flg, wr_cnt;

  assign wr_ctrl = wr_en_i && wr_sel_i == 2'd0;
  assign wr_flg  = wr_en_i && wr_sel_i == 2'd1;
  assign wr_cnt  = wr_en_i && wr_sel_i == 2'd2;

  assign rise     = sync_q[1] & ~sync_q[2];
  assign fall     = ~sync_q[1] & sync_q[2];
  assign edge_sel = mode_q[0] ? rise : fall;
  assign lvl_on   = mode_q[0] ? ~sync_q[1] : sync_q[1];
  assign div_tick = div_q == DW'(GATE_DIV - 1);

  assign cnt_tick = en_q & (mode_q[1] ? (div_tick & lvl_on) : edge_sel);
  assign in_evt   = en_q & edge_sel;
  assign wrap     = cnt_tick & (&cnt_q);
  assign tap      = cnt_tick & (&cnt_q[TAP_BITS-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                div_q <= '0;
    else if (!en_q || div_tick) div_q <= '0;
    else                        div_q <= div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= '0; csel_q <= '0; ie_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= wr_data_i[6];
      mode_q <= wr_data_i[5:4];
      csel_q <= wr_data_i[3:2];
      ie_q   <= wr_data_i[1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flg_q <= '0;
    else        flg_q <= (flg_q & ~(wr_flg ? wr_data_i[1:0] : 2'b00)) | {wrap, in_evt};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= wr_data_i;
    else if (cnt_tick) cnt_q <= cnt_q + 1'b1;

  always_comb
    case (csel_q)
      2'b00:   tmr_tick_o = presc_tick_i;
      2'b01:   tmr_tick_o = cnt_tick;
      2'b10:   tmr_tick_o = tap;
      default: tmr_tick_o = wrap;
    endcase

  assign ctrl_o  = {1'b0, en_q, mode_q, csel_q, ie_q};
  assign flags_o = flg_q;
  assign count_o = cnt_q;
  assign irq_o   = |(flg_q & ie_q);
endmodule

module pulse_acc_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en_i,
  input logic [1:0]    wr_sel_i,
  input logic [CW-1:0] wr_data_i,
  input logic [7:0]    ctrl_o,
  input logic [1:0]    flags_o,
  input logic [CW-1:0] count_o,
  input logic          tmr_tick_o
);
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ctrl_o[7] == 1'b0); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1)); // R3
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[6] && !wr_en_i) |=> $stable(count_o)); // R5
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !flags_o[1] && count_o != '1) |=> !flags_o[1]); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[0] && !(wr_en_i && wr_sel_i == 2'd1 && wr_data_i[0])) |=> flags_o[0]); // R8
  AST_TAP_BYTE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[3:2] == 2'b10 && tmr_tick_o && !wr_en_i) |=> count_o[7:0] == 8'h00); // R11
endmodule

bind pulse_acc pulse_acc_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .ctrl_o(ctrl_o), .flags_o(flags_o),
  .count_o(count_o), .tmr_tick_o(tmr_tick_o)
);

// File: tb/pulse_acc_tb.sv
module pulse_acc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, presc = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] ctrl;
  logic [1:0] flags;
  logic [15:0] count;
  logic irq, tick;
  int total = 0, fails = 0, ticks_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_acc dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .presc_tick_i(presc),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .flags_o(flags), .count_o(count), .irq_o(irq), .tmr_tick_o(tick)
  );

  always @(negedge clk) if (rst_n && tick) ticks_seen++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pin = 1'b1; idle(3); pin = 1'b0; idle(3);
    end
    idle(4);
  endtask

  task automatic setup(input logic [7:0] c, input logic [15:0] cnt);
    wr(2'd0, 16'h0000); wr(2'd2, cnt); wr(2'd1, 16'h0003); wr(2'd0, {8'h00, c});
  endtask

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    chk("R1 ctrl", ctrl, 0); chk("R1 flags", flags, 0); chk("R1 count", count, 0);

    wr(2'd0, 16'h00FF);
    chk("R2 ctrl bit7 reads 0", ctrl, 8'h7F);

    for (int m = 0; m < 2; m++)
      for (int n = 0; n <= 8; n++) begin
        setup(8'h40 | 8'(m << 4), 16'h0000);
        pulses(n);
        chk($sformatf("R3 mode%0d edges=%0d", m, n), count, n);
        chk("R7 event flag", flags[0], n > 0 ? 1 : 0);
      end

    setup(8'h10, 16'h0055);
    pulses(5);
    chk("R5 disabled count", count, 16'h0055);
    chk("R5 disabled flags", flags, 0);

    pin = 1'b1; setup(8'h00, 16'h0000); idle(5);
    wr(2'd0, 16'h0060);
    idle(64 * 3 + 2);
    chk("R4 gated high count", count, 3);
    chk("R7 no flag during gate", flags[0], 0);
    pin = 1'b0; idle(200);
    chk("R4 gate closed hold", count, 3);
    chk("R7 trailing fall flag", flags[0], 1);

    setup(8'h00, 16'h0000); idle(5);
    wr(2'd0, 16'h0070);
    idle(64 * 2 + 2);
    chk("R4 gated low count", count, 2);
    pin = 1'b1; idle(10);
    chk("R7 trailing rise flag", flags[0], 1);
    pin = 1'b0; idle(5);

    setup(8'h60, 16'h0000);
    idle(300);
    chk("R4 inactive level no count", count, 0);

    setup(8'h52, 16'hFFFE);
    pulses(1);
    chk("R9 irq masked", irq, 0);
    chk("R6 no ovf yet", flags, 2'b01);
    pulses(1);
    chk("R6 wrap count", count, 0);
    chk("R6 ovf flag", flags, 2'b11);
    chk("R9 irq asserted", irq, 1);
    wr(2'd1, 16'h0002);
    chk("R8 w1c ovf only", flags, 2'b01);
    chk("R9 irq dropped", irq, 0);
    wr(2'd1, 16'h0000);
    chk("R8 write zero keeps", flags, 2'b01);

    setup(8'h50, 16'hFFFF); idle(2);
    @(negedge clk); pin = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk); wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0003;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    chk("R8 set beats clear", flags, 2'b11);
    chk("R6 wrap at collision", count, 0);
    pin = 1'b0; idle(6);
    @(negedge clk); pin = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'h1234;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    idle(4);
    chk("R10 write beats step", count, 16'h1234);
    pin = 1'b0; idle(6);

    setup(8'h54, 16'h0000); ticks_seen = 0;
    pulses(10);
    chk("R11 select 01 ticks", ticks_seen, 10);
    setup(8'h58, 16'h00F0); ticks_seen = 0;
    pulses(300);
    chk("R11 select 10 ticks", ticks_seen, 2);
    chk("R3 long run count", count, 16'h00F0 + 300);
    setup(8'h5C, 16'hFFF0); ticks_seen = 0;
    pulses(20);
    chk("R11 select 11 ticks", ticks_seen, 1);
    setup(8'h40, 16'h0000);
    @(negedge clk); presc = 1'b1; #1;
    chk("R11 select 00 high", tick, 1);
    @(negedge clk); presc = 1'b0; #1;
    chk("R11 select 00 low", tick, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); total++; fails++; $display("FAIL watchdog expired"); end
    join_any
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule